// File: doc/BRIEF.md
# Output-Stationary Systolic FIR Array

This block evaluates a batch of N consecutive outputs of a K-tap FIR filter on a linear row of N processing elements. Each element owns one output and keeps its accumulator in place for the whole job. The filter is y[i] = sum over j = 0..K-1 of w[j] * x[i+j], with all indices counted from 0. On each compute step one coefficient is broadcast to every element at once. Samples do not go to all elements at once. They enter at the high end of the row and move one element down per accepted beat, through a register in each element. Neighbouring elements therefore always multiply samples whose indices differ by one.

A job runs as follows. The user pulses `start`. The user then streams N-1 fill samples x[0]..x[N-2], then K paired beats that each carry a coefficient w[j] and the sample x[N-1+j]. Whenever a valid line is low, the array stalls. When the last step is taken, `done` pulses and the N signed sums stay on `results` until the next job begins.

The controller is a four-state machine:
- IDLE waits for `start` (transition *launch*). It goes to FILL, or straight to RUN when N is 1.
- FILL counts fill samples. Its transition *primed* leads to RUN after the (N-1)-th sample.
- RUN counts steps. Its transition *finish* leads to DONE on step K.
- DONE lasts exactly one cycle. Its transition *retire* leads back to IDLE.

Top module: `sys_fir_array`

## Requirements
- R1: While reset is active and right after it, `done` is 0, the state is IDLE and every field of `results` is 0.
- R2: A `start` pulse seen in IDLE clears every accumulator and every sample register, so in the next cycle all result fields read 0.
- R3: In FILL, a cycle with `samp_vld` high shifts `samp` into the row and accumulates nothing. `coef_vld` and `coef` have no effect during FILL, and FILL ends after N-1 samples.
- R4: In RUN, a step is taken only in a cycle where `samp_vld` and `coef_vld` are both high. That step broadcasts `coef` to all elements and shifts `samp` into the row before the multiply.
- R5: After the K-th step, field i of `results` equals the exact signed sum over j of w[j]*x[i+j]. This holds for any W-bit two's-complement inputs, because each accumulator is 2*W+clog2(K) bits wide.
- R6: In FILL, a cycle with `samp_vld` low leaves all sample registers and accumulators unchanged. In RUN, a cycle where either valid is low also leaves them unchanged.
- R7: `done` is high for exactly one cycle: the cycle right after the edge that takes the K-th step. It is never high at any other time during a job.
- R8: Outside FILL and RUN, `results` holds its value whatever the valid and data inputs do, until the next accepted `start`.
- R9: Element i drives `results[i*AW +: AW]`, where AW = 2*W+clog2(K), in two's complement.
- R10: A `start` pulse while FILL or RUN is active is ignored. It neither clears state nor restarts the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, accepted in IDLE only |
| coef_vld | input | 1 | Coefficient valid |
| coef | input | W | Signed coefficient, broadcast to every element |
| samp_vld | input | 1 | Sample valid |
| samp | input | W | Signed sample, entering at element N-1 |
| done | output | 1 | One-cycle completion pulse |
| results | output | N*AW | Packed signed sums, element i at bits i*AW upward |

## Verification
The bench runs many jobs on a 4-element, 3-tap, 4-bit configuration. The jobs include all-extreme operands that reach the full accumulator width, ramps, and pseudo-random data. A design that dropped the guard bits or multiplied without sign would produce wrong values in the extreme jobs. Other jobs insert stall cycles with only one valid high, feed junk coefficients during the fill, and pulse `start` in the middle of a job. A design that stepped on a single valid, consumed a coefficient while filling, or restarted while busy would shift the sample window and return sums taken from the wrong indices. After each job the bench also checks the exact cycle of `done`, the clearing done by the next launch, and that results stay fixed while inputs keep toggling.

// File: rtl/sfir_pkg.sv
package sfir_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } sfir_state_e;

    // Accumulator width needed for K exact signed W x W products.
    function automatic int sfir_acc_width(input int w, input int k);
        return 2 * w + $clog2(k);
    endfunction

endpackage

// File: rtl/sfir_ctrl.sv
module sfir_ctrl
    import sfir_pkg::*;
#(
    parameter int N = 4,
    parameter int K = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic samp_vld,
    input  logic coef_vld,
    output logic clr,
    output logic shift_en,
    output logic acc_en,
    output logic done,
    output logic busy
);

    localparam int FW = (N > 1) ? $clog2(N) : 1;
    localparam int SW = (K > 1) ? $clog2(K) : 1;
    localparam logic [FW-1:0] FILL_LAST = FW'((N > 1) ? N - 2 : 0);
    localparam logic [SW-1:0] STEP_LAST = SW'(K - 1);

    sfir_state_e state_q, state_d;
    logic [FW-1:0] fill_cnt;
    logic [SW-1:0] step_cnt;
    logic          fill_beat, step_beat;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: launch, primed, finish, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = (N > 1) ? ST_FILL : ST_RUN;
            ST_FILL: if (samp_vld && fill_cnt == FILL_LAST) state_d = ST_RUN;
            ST_RUN:  if (samp_vld && coef_vld && step_cnt == STEP_LAST) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        clr       = 1'b0;
        fill_beat = 1'b0;
        step_beat = 1'b0;
        done      = 1'b0;
        busy      = 1'b0;
        unique case (state_q)
            ST_IDLE: clr = start;
            ST_FILL: begin
                busy      = 1'b1;
                fill_beat = samp_vld;
            end
            ST_RUN: begin
                busy      = 1'b1;
                step_beat = samp_vld && coef_vld;
            end
            ST_DONE: done = 1'b1;
        endcase
        shift_en = fill_beat || step_beat;
        acc_en   = step_beat;
    end

    // Beat counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_cnt <= '0;
            step_cnt <= '0;
        end else if (clr) begin
            fill_cnt <= '0;
            step_cnt <= '0;
        end else begin
            if (fill_beat) fill_cnt <= fill_cnt + 1'b1;
            if (step_beat) step_cnt <= step_cnt + 1'b1;
        end
    end

    // R7: completion pulse is a single cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: completion only follows a compute phase
    a_r7_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(state_q == ST_RUN));

    // R4: every accumulate also moves the sample row
    a_r4_step_shifts: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |-> shift_en);

    // R10: a busy array never clears
    a_r10_no_clear_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !clr);

    // R3: nothing is accumulated while filling
    a_r3_fill_no_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |-> !acc_en);

endmodule

// File: rtl/sfir_pe.sv
module sfir_pe #(
    parameter int W  = 8,
    parameter int AW = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 shift_en,
    input  logic                 acc_en,
    input  logic signed [W-1:0]  coef,
    input  logic signed [W-1:0]  smp_in,
    output logic signed [W-1:0]  smp_out,
    output logic signed [AW-1:0] acc_out
);

    logic signed [W-1:0]   s_q;
    logic signed [AW-1:0]  acc_q;
    logic signed [2*W-1:0] prod;

    // The multiply uses the sample arriving on this beat (retimed chain).
    assign prod = coef * smp_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q   <= '0;
            acc_q <= '0;
        end else if (clr) begin
            s_q   <= '0;
            acc_q <= '0;
        end else begin
            if (shift_en) s_q   <= smp_in;
            if (acc_en)   acc_q <= acc_q + AW'(prod);
        end
    end

    assign smp_out = s_q;
    assign acc_out = acc_q;

    // R6: a stalled cycle keeps the sample register
    a_r6_sample_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !clr) |=> $stable(s_q));

    // R6: a stalled cycle keeps the accumulator
    a_r6_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && !clr) |=> $stable(acc_q));

    // R2: launch empties the element
    a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0 && s_q == '0));

endmodule

// File: rtl/sys_fir_array.sv
module sys_fir_array
    import sfir_pkg::*;
#(
    parameter int N = 4,
    parameter int K = 3,
    parameter int W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic                              coef_vld,
    input  logic [W-1:0]                      coef,
    input  logic                              samp_vld,
    input  logic [W-1:0]                      samp,
    output logic                              done,
    output logic [N*(2*W+$clog2(K))-1:0]      results
);

    localparam int AW = sfir_acc_width(W, K);

    logic clr, shift_en, acc_en, busy;
    logic signed [W-1:0]  link  [0:N];
    logic signed [AW-1:0] acc_w [0:N-1];

    sfir_ctrl #(.N(N), .K(K)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .samp_vld (samp_vld),
        .coef_vld (coef_vld),
        .clr      (clr),
        .shift_en (shift_en),
        .acc_en   (acc_en),
        .done     (done),
        .busy     (busy)
    );

    assign link[N] = samp;

    for (genvar i = 0; i < N; i++) begin : g_pe
        sfir_pe #(.W(W), .AW(AW)) u_pe (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr),
            .shift_en (shift_en),
            .acc_en   (acc_en),
            .coef     (coef),
            .smp_in   (link[i+1]),
            .smp_out  (link[i]),
            .acc_out  (acc_w[i])
        );
        assign results[i*AW +: AW] = acc_w[i];
    end

    // R3: the row end receives its upstream neighbour's sample on a shift
    a_r3_chain_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !clr) |=> (link[0] == $past(link[1])));

    // R8: results are frozen outside an active job
    a_r8_results_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(results));

endmodule

// File: tb/sys_fir_array_test.sv
module sys_fir_array_test;

    localparam int N  = 4;
    localparam int K  = 3;
    localparam int W  = 4;
    localparam int AW = 2 * W + $clog2(K);
    localparam int NS = N + K - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic coef_vld = 1'b0;
    logic samp_vld = 1'b0;
    logic [W-1:0] coef = '0;
    logic [W-1:0] samp = '0;
    logic done;
    logic [N*AW-1:0] results;

    int checks = 0;
    int fails  = 0;
    int xs [NS];
    int ws [K];
    int expv [N];
    int seed = 32'h1234_5678;

    // 20-unit period: 50 MHz at 1 ns units
    always #10 clk = ~clk;

    sys_fir_array #(.N(N), .K(K), .W(W)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .coef_vld (coef_vld),
        .coef     (coef),
        .samp_vld (samp_vld),
        .samp     (samp),
        .done     (done),
        .results  (results)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int res(input int i);
        logic signed [AW-1:0] v;
        v = results[i*AW +: AW];
        return int'(v);
    endfunction

    function automatic int rnd_val();
        seed = seed * 1103515245 + 12345;
        return ((seed >>> 16) & 15) - 8;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // stall: insert wait cycles; junk: coef_vld high in fill and in stalls;
    // midstart: pulse start during stall cycles
    task automatic run_job(input int stall, input int junk, input int midstart);
        int early;
        for (int i = 0; i < N; i++) begin
            expv[i] = 0;
            for (int j = 0; j < K; j++) expv[i] += ws[j] * xs[i + j];
        end
        early = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < N; i++) chk("R2 clear on launch", res(i), 0);

        // fill phase (R3, R6)
        for (int f = 0; f < N - 1; f++) begin
            if (stall != 0) begin
                samp_vld = 1'b0;
                samp     = W'(rnd_val());
                coef_vld = junk[0];
                coef     = W'(rnd_val());
                start    = midstart[0];
                @(negedge clk);
                early |= int'(done);
            end
            start    = 1'b0;
            samp_vld = 1'b1;
            samp     = W'(xs[f]);
            coef_vld = junk[0];
            coef     = W'(rnd_val());
            @(negedge clk);
            early |= int'(done);
        end

        // compute steps (R4, R6, R10)
        for (int j = 0; j < K; j++) begin
            if (stall != 0) begin
                samp_vld = j[0];
                coef_vld = ~j[0];
                samp     = W'(rnd_val());
                coef     = W'(rnd_val());
                start    = midstart[0];
                @(negedge clk);
                early |= int'(done);
            end
            start    = 1'b0;
            samp_vld = 1'b1;
            coef_vld = 1'b1;
            samp     = W'(xs[N - 1 + j]);
            coef     = W'(ws[j]);
            @(negedge clk);
            if (j < K - 1) early |= int'(done);
        end
        samp_vld = junk[0];
        coef_vld = junk[0];
        samp     = W'(rnd_val());
        coef     = W'(rnd_val());
        chk("R7 no early done", early, 0);
        chk("R7 done after last step", int'(done), 1);
        for (int i = 0; i < N; i++) chk("R5 R9 result field", res(i), expv[i]);
        @(negedge clk);
        chk("R7 done single cycle", int'(done), 0);

        // hold while inputs toggle (R8)
        for (int c = 0; c < 3; c++) begin
            samp_vld = 1'b1;
            coef_vld = 1'b1;
            samp     = W'(rnd_val());
            coef     = W'(rnd_val());
            @(negedge clk);
        end
        samp_vld = 1'b0;
        coef_vld = 1'b0;
        for (int i = 0; i < N; i++) chk("R8 results held", res(i), expv[i]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        chk("R1 done in reset", int'(done), 0);
        chk("R1 results in reset", int'(results != '0), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", int'(done), 0);
        for (int i = 0; i < N; i++) chk("R1 results after reset", res(i), 0);

        // job 0: unit values
        for (int s = 0; s < NS; s++) xs[s] = 1;
        for (int j = 0; j < K; j++) ws[j] = 1;
        run_job(0, 0, 0);

        // job 1: most negative times most negative (R5 width)
        for (int s = 0; s < NS; s++) xs[s] = -8;
        for (int j = 0; j < K; j++) ws[j] = -8;
        run_job(1, 1, 0);

        // job 2: most negative times most positive
        for (int s = 0; s < NS; s++) xs[s] = 7;
        for (int j = 0; j < K; j++) ws[j] = -8;
        run_job(0, 1, 1);

        // job 3: ramp, distinct per index (window alignment)
        for (int s = 0; s < NS; s++) xs[s] = s - 3;
        for (int j = 0; j < K; j++) ws[j] = 2 * j - 3;
        run_job(1, 0, 1);

        // pseudo-random sweep over stall, junk and mid-start combinations
        for (int r = 0; r < 24; r++) begin
            for (int s = 0; s < NS; s++) xs[s] = rnd_val();
            for (int j = 0; j < K; j++) ws[j] = rnd_val();
            run_job(r & 1, (r >> 1) & 1, (r >> 2) & 1);
        end

        // R10: start while busy must not clear partial state
        for (int s = 0; s < NS; s++) xs[s] = s + 1;
        for (int j = 0; j < K; j++) ws[j] = j + 1;
        run_job(1, 1, 1);

        summary();
        $finish;
    end

endmodule